// File: doc/BRIEF.md
# PLL Bandwidth Control and Crystal-Loss Status Register

This block holds the bandwidth-control register of a clock-generator PLL. It sits on an 8-bit peripheral register bus made of select, write enable, write data and read data. It chooses whether the PLL loop runs in acquisition or tracking mode. In manual mode software picks the mode. In automatic mode an external bandwidth controller picks it. The block drives the chosen mode on `acq_trk_out`.

The mode bit changes role with the automatic-mode bit. While automatic mode is on, the bit reports the controller's choice and ignores writes. The last manual choice is kept untouched during that time and is back in effect as soon as manual mode resumes. The lock indication from the PLL is visible only in automatic mode.

A crystal-loss check runs in the block's clock domain. That clock is the VCO-derived system clock. Software writes 1 to the loss bit, and the block then opens a window of 4×N clock cycles, where N is the multiplier input. The reference clock is resynchronised with two flops. A rising reference edge inside the window clears the pending loss flag. The check is gated by the clock-source select `vco_sel`.

The detector has three states:
- `DET_IDLE`: no result is held.
- `DET_WINDOW`: counting.
- `DET_RESULT`: the verdict is held.

Its transitions are:
- IDLE→WINDOW, RESULT→WINDOW and WINDOW→WINDOW (restart): on a start write.
- WINDOW→RESULT: when the count reaches 4×N.
- Any state→IDLE: when `vco_sel` is 0.

Top module: `pll_bwctl`

Register layout, bit 7 down to bit 0:
- Bit 7 (AUTO): automatic mode.
- Bit 6 (LOCK): lock status.
- Bit 5 (ACQ): 1 = tracking, 0 = acquisition.
- Bit 4 (XLD): crystal loss.
- Bits 3..0: reserved.

## Requirements
- R1: After reset the register reads 0x00 and `acq_trk_out` is 0 (acquisition).
- R2: Bit 6 reads `pll_lock` when AUTO is 1 and reads 0 when AUTO is 0.
- R3: Bit 7 (AUTO) is read/write through the bus and resets to 0.
- R4: When AUTO is 1, bit 5 reads `auto_trk` and `acq_trk_out` equals `auto_trk`. A write made while AUTO is 1 does not change the stored manual value.
- R5: When AUTO is 0, a write stores bit 5 as the manual mode. Bit 5 reads it back and `acq_trk_out` equals it. Whether a write is taken as manual is decided by AUTO as it stood before that write.
- R6: The manual value stored before entering automatic mode is read back on bit 5 and driven on `acq_trk_out` after AUTO returns to 0.
- R7: Bit 4 reads 0 while `vco_sel` is 0. A 1 written to bit 4 while `vco_sel` is 0 starts no check. Dropping `vco_sel` discards any check or result.
- R8: After a 1 is written to bit 4 with `vco_sel` 1, bit 4 reads 0 during the 4×N-cycle window. From then on it reads 1 if no rising reference edge was seen in the window, and 0 if one was seen.
- R9: Writing 1 to bit 4 during a window restarts the window. Writing 0 to bit 4 leaves a running check or a held result unchanged.
- R10: Bits 3..0 always read 0. `rdata` is 0 when `sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-derived system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, qualified by sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while sel is 1 |
| pll_lock | input | 1 | Lock indication from the PLL |
| auto_trk | input | 1 | Mode from the automatic bandwidth controller (1 = tracking) |
| vco_sel | input | 1 | 1 when the VCO clock drives the system clock |
| ref_clk | input | 1 | Crystal reference clock, asynchronous |
| mul_n | input | MUL_W | VCO multiplier N |
| acq_trk_out | output | 1 | Effective mode to the PLL (1 = tracking) |

## Verification
Read data is combinational, so a write taken at a clock edge shows on `rdata` from that edge on. The bench samples at the following falling edge. Changes on `pll_lock`, `auto_trk` and `vco_sel` show in the same cycle. A loss verdict needs 4×N edges after the write edge, so the bench waits 4×N+2 falling edges before reading it and checks within the window at 10 edges. Each reference-stopped case first waits with the reference held still, so the synchroniser carries no stale edge into the window.

// File: rtl/pll_bwctl_pkg.sv
package pll_bwctl_pkg;
    typedef enum logic [1:0] {
        DET_IDLE   = 2'd0,
        DET_WINDOW = 2'd1,
        DET_RESULT = 2'd2
    } det_state_t;

    localparam int BIT_AUTO = 7;
    localparam int BIT_LOCK = 6;
    localparam int BIT_ACQ  = 5;
    localparam int BIT_XLD  = 4;
    localparam int RSVD_W   = 4;
endpackage

// File: rtl/pll_bwctl_acq.sv
module pll_bwctl_acq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic w_auto,
    input  logic w_acq,
    input  logic auto_trk,
    output logic auto_q,
    output logic acq_eff
);
    logic manual_acq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q     <= 1'b0;
            manual_acq <= 1'b0;
        end else if (wr) begin
            auto_q <= w_auto;
            if (!auto_q)
                manual_acq <= w_acq;
        end
    end

    always_comb acq_eff = auto_q ? auto_trk : manual_acq;

    AST_ACQ_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        auto_q |=> $stable(manual_acq)); // R6
endmodule

// File: rtl/pll_bwctl_xdet.sv
module pll_bwctl_xdet
    import pll_bwctl_pkg::*;
#(
    parameter int MUL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             vco_sel,
    input  logic             ref_clk,
    input  logic [MUL_W-1:0] mul_n,
    output logic             xld_flag
);
    localparam int CNT_W = MUL_W + 2;

    det_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             loss;
    logic             ref_meta, ref_sync, ref_prev;
    logic             ref_rise;
    logic             last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_meta <= 1'b0;
            ref_sync <= 1'b0;
            ref_prev <= 1'b0;
        end else begin
            ref_meta <= ref_clk;
            ref_sync <= ref_meta;
            ref_prev <= ref_sync;
        end
    end

    always_comb begin
        ref_rise = ref_sync & ~ref_prev;
        limit    = {mul_n, 2'b00};
        last     = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DET_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!vco_sel) begin
            nxt = DET_IDLE;
        end else begin
            unique case (state)
                DET_IDLE:   if (start) nxt = DET_WINDOW;
                DET_WINDOW: if (start) nxt = DET_WINDOW;
                            else if (last) nxt = DET_RESULT;
                DET_RESULT: if (start) nxt = DET_WINDOW;
                default:    nxt = DET_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            loss <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            loss <= 1'b1;
        end else if (state == DET_WINDOW) begin
            cnt <= cnt + 1'b1;
            if (ref_rise) loss <= 1'b0;
        end
    end

    always_comb xld_flag = (state == DET_RESULT) && loss;

    AST_XLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_sel |=> (state == DET_IDLE)); // R7
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_WINDOW) |-> (cnt < limit || limit == '0)); // R8
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == DET_WINDOW && cnt == '0)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_RESULT && !start && vco_sel) |=> (state == DET_RESULT && $stable(loss))); // R8
endmodule

// File: rtl/pll_bwctl.sv
module pll_bwctl
    import pll_bwctl_pkg::*;
#(
    parameter int MUL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             pll_lock,
    input  logic             auto_trk,
    input  logic             vco_sel,
    input  logic             ref_clk,
    input  logic [MUL_W-1:0] mul_n,
    output logic             acq_trk_out
);
    logic wr;
    logic auto_q;
    logic xld_flag;
    logic start;

    always_comb begin
        wr    = sel & wr_en;
        start = wr & wdata[BIT_XLD] & vco_sel;
    end

    pll_bwctl_acq u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .w_auto   (wdata[BIT_AUTO]),
        .w_acq    (wdata[BIT_ACQ]),
        .auto_trk (auto_trk),
        .auto_q   (auto_q),
        .acq_eff  (acq_trk_out)
    );

    pll_bwctl_xdet #(.MUL_W(MUL_W)) u_xdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vco_sel  (vco_sel),
        .ref_clk  (ref_clk),
        .mul_n    (mul_n),
        .xld_flag (xld_flag)
    );

    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[BIT_AUTO] = auto_q;
            rdata[BIT_LOCK] = auto_q & pll_lock;
            rdata[BIT_ACQ]  = acq_trk_out;
            rdata[BIT_XLD]  = vco_sel & xld_flag;
        end
    end

    AST_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rdata[BIT_AUTO]) |-> !rdata[BIT_LOCK]); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[RSVD_W-1:0] == '0); // R10
    AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> rdata == '0); // R10
endmodule

// File: tb/pll_bwctl_tb.sv
module pll_bwctl_tb;
    localparam int MUL_W = 4;
    localparam int NMUL  = 4;
    localparam int WIN   = 4 * NMUL;

    typedef struct packed {
        logic [7:0] w;
        logic       lk;
        logic       tr;
        logic [7:0] rd;
        logic       out;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'h00, 1'b1, 1'b1, 8'h00, 1'b0},   // R2 lock masked in manual
        '{8'h20, 1'b1, 1'b0, 8'h20, 1'b1},   // R5 manual tracking
        '{8'hA0, 1'b1, 1'b0, 8'hC0, 1'b0},   // R3 R2 R4 enter auto
        '{8'h80, 1'b0, 1'b1, 8'hA0, 1'b1},   // R4 auto mode reported
        '{8'h00, 1'b1, 1'b0, 8'h20, 1'b1},   // R6 restore manual 1
        '{8'h0F, 1'b1, 1'b0, 8'h00, 1'b0},   // R10 reserved read 0
        '{8'h80, 1'b1, 1'b1, 8'hE0, 1'b1},   // R4 auto again
        '{8'h20, 1'b1, 1'b1, 8'h00, 1'b0}    // R4 R6 write in auto ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic pll_lock = 1'b0, auto_trk = 1'b0, vco_sel = 1'b0;
    logic ref_clk = 1'b0, ref_run = 1'b0;
    logic [MUL_W-1:0] mul_n = MUL_W'(NMUL);
    logic acq_trk_out;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;
    always #15 if (ref_run) ref_clk = ~ref_clk;

    pll_bwctl #(.MUL_W(MUL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pll_lock(pll_lock), .auto_trk(auto_trk),
        .vco_sel(vco_sel), .ref_clk(ref_clk), .mul_n(mul_n),
        .acq_trk_out(acq_trk_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        waitn(3);
        sel = 1'b1;
        chk("R1 reset rdata", rdata, 8'h00);
        chk("R1 reset acq_trk_out", {7'b0, acq_trk_out}, 8'h00);
        rst_n = 1'b1;
        waitn(2);
        chk("R1 after reset release", rdata, 8'h00);

        for (int i = 0; i < 8; i++) begin
            bus_wr(VEC[i].w);
            pll_lock = VEC[i].lk;
            auto_trk = VEC[i].tr;
            #1;
            chk($sformatf("R2-R6 vector %0d rdata", i), rdata, VEC[i].rd);
            chk($sformatf("R4 R5 vector %0d acq_trk_out", i), {7'b0, acq_trk_out}, {7'b0, VEC[i].out});
        end

        sel = 1'b0; #1;
        chk("R10 rdata with sel low", rdata, 8'h00);
        sel = 1'b1;

        // R8 reference running
        vco_sel = 1'b1; ref_run = 1'b1;
        waitn(4);
        bus_wr(8'h10);
        waitn(5);
        chk("R8 window reads 0", rdata & 8'h10, 8'h00);
        waitn(WIN + 2);
        chk("R8 ref running xld", rdata & 8'h10, 8'h00);

        // R8 reference stopped
        ref_run = 1'b0;
        waitn(10);
        bus_wr(8'h10);
        waitn(10);
        chk("R8 stopped window reads 0", rdata & 8'h10, 8'h00);
        waitn(WIN);
        chk("R8 ref stopped xld", rdata & 8'h10, 8'h10);

        // R9 write 0 keeps result
        bus_wr(8'h00);
        chk("R9 write 0 keeps result", rdata & 8'h10, 8'h10);

        // R9 restart
        bus_wr(8'h10);
        waitn(8);
        bus_wr(8'h10);
        waitn(10);
        chk("R9 restart still in window", rdata & 8'h10, 8'h00);
        waitn(8);
        chk("R9 restart result", rdata & 8'h10, 8'h10);

        // R7 gating
        vco_sel = 1'b0; #1;
        chk("R7 xld masked by vco_sel", rdata & 8'h10, 8'h00);
        waitn(2);
        vco_sel = 1'b1; #1;
        chk("R7 result discarded", rdata & 8'h10, 8'h00);
        vco_sel = 1'b0;
        bus_wr(8'h10);
        vco_sel = 1'b1;
        waitn(WIN + 4);
        chk("R7 no check started while vco_sel 0", rdata & 8'h10, 8'h00);
        chk("R10 reserved bits", rdata & 8'h0F, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule